// File: doc/BRIEF.md
# Programmable shortened Reed-Solomon encoder

This block is a systematic Reed-Solomon encoder over GF(2^8) with 16 check symbols per codeword, enough for a decoder to repair up to 8 corrupted bytes. Bytes arrive on a valid/ready stream at up to one per clock. For every codeword the encoder forwards the message bytes untouched and then emits the 16 check bytes it computed from them. It flags the final check byte so the next stage can find codeword boundaries.

The codeword length n is set through a small configuration port and may be any value from 50 to 255. Shorter lengths give a shortened code with n-16 message bytes. A length written while a codeword is in flight waits and takes effect on the first byte of the next codeword, so the setting can change under live traffic. Out-of-range lengths are rejected and flagged. A bypass setting turns coding off, and the stream then passes straight through.

Top module: `rs_encoder`

## Requirements
- R1: For each codeword, the output is the accepted message bytes in order, followed by 16 check bytes. The check bytes are the remainder of m(x)·x^16 divided by g(x) = (x-α^0)(x-α^1)…(x-α^15) over the field built on x^8+x^4+x^3+x^2+1. The first byte out is the highest-degree coefficient, so the syndromes at α^0..α^15 of the emitted codeword are all zero.
- R2: With active length n (50..255), exactly n-16 message bytes are accepted per codeword, and n bytes in total leave for it.
- R3: `out_last` is high on the final check byte of each coded codeword and on no other output byte.
- R4: While message bytes are expected and `out_ready` is held high, one byte is accepted on every clock. While check bytes are being emitted, `in_ready` is low.
- R5: A byte accepted on clock edge k, with no stall on edge k+1, is presented on `out_data` with `out_valid` high right after edge k+1. It is not presented before that.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady and `in_ready` is low.
- R7: A configuration write made in the middle of a codeword does not change that codeword. The new length and bypass setting apply from the first byte of the next codeword.
- R8: A write with `cfg_len` below 50 or above 255 is ignored (length and bypass stay as they were) and sets `cfg_err`. The next write with a legal length clears `cfg_err`.
- R9: With bypass active, every accepted byte leaves unchanged and in order, no check bytes are added, and `out_last` stays low.
- R10: After reset, `out_valid` and `cfg_err` are low, `in_ready` is high, and the encoder codes with n = 255 and bypass off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_len | input | 8 | Requested codeword length n |
| cfg_bypass | input | 1 | Requested bypass setting (1 = no coding) |
| cfg_err | output | 1 | Last configuration write carried an illegal length |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Encoder can accept an input byte this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Output byte (message or check) |
| out_last | output | 1 | Output byte is the last of a codeword |

## Verification
The assertions assume that `rst_n` is held low for at least two clocks at start-up. They also assume that `cfg_len` is sampled only on the cycle `cfg_wr` is high. Both the `in_*` and `out_ready` sides may change on any cycle. The stimulus applies every input change on the falling clock edge and holds reset low for three clocks. It changes the configuration only with a single-cycle strobe, either between codewords or, in the mid-codeword case, during a deliberate input gap. Backpressure comes from a fixed repeating `out_ready` pattern or a forced hold, so every stall state is reached without random inputs.

// File: rtl/rs_enc_pkg.sv
// Shared symbol type and Galois-field helpers for the encoder.
// Assumes: 8-bit symbols, 16 check symbols, primitive field polynomial given
// by its low 8 taps (x^8 implied).
package rs_enc_pkg;

    localparam int SYM_W = 8;
    localparam int NPAR  = 16;

    typedef logic [SYM_W-1:0] sym_t;

    // Multiply two field elements, reducing by the field polynomial taps.
    function automatic sym_t gf_mul(sym_t a, sym_t b, sym_t taps);
        sym_t acc;
        sym_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[SYM_W-1] ? ((x << 1) ^ taps) : (x << 1);
        end
        return acc;
    endfunction

    // Coefficients g0..g(NPAR-1) of the monic generator with consecutive
    // roots alpha^first .. alpha^(first+NPAR-1); g0 sits in the low byte.
    function automatic logic [NPAR*SYM_W-1:0] gen_coefs(sym_t taps, int first);
        logic [(NPAR+1)*SYM_W-1:0] g;
        sym_t root;
        sym_t lower;
        sym_t upper;
        g = '0;
        g[SYM_W-1:0] = sym_t'(1);
        root = sym_t'(1);
        for (int k = 0; k < first; k++) root = gf_mul(root, sym_t'(2), taps);
        for (int i = 0; i < NPAR; i++) begin
            for (int j = NPAR; j > 0; j--) begin
                lower = g[(j-1)*SYM_W +: SYM_W];
                upper = g[j*SYM_W +: SYM_W];
                g[j*SYM_W +: SYM_W] = lower ^ gf_mul(upper, root, taps);
            end
            g[SYM_W-1:0] = gf_mul(g[SYM_W-1:0], root, taps);
            root = gf_mul(root, sym_t'(2), taps);
        end
        return g[NPAR*SYM_W-1:0];
    endfunction

endpackage

// File: rtl/rs_cfg_regs.sv
// Configuration holding register: keeps the most recent legal length and
// bypass request, and flags writes whose length is out of range.
// Assumes: cfg_len is only meaningful while cfg_wr is high.
module rs_cfg_regs
    import rs_enc_pkg::*;
#(
    parameter int MIN_LEN = 50,
    parameter int MAX_LEN = 255,
    parameter int DEF_LEN = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  sym_t cfg_len,
    input  logic cfg_bypass,
    output sym_t pend_len,
    output logic pend_byp,
    output logic cfg_err
);

    logic len_ok;

    assign len_ok = (int'(cfg_len) >= MIN_LEN) && (int'(cfg_len) <= MAX_LEN);

    // Capture a legal request; an illegal one leaves the pending values alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_len <= sym_t'(DEF_LEN);
            pend_byp <= 1'b0;
        end else if (cfg_wr && len_ok) begin
            pend_len <= cfg_len;
            pend_byp <= cfg_bypass;
        end
    end

    // Error flag follows the legality of the latest write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_err <= 1'b0;
        else if (cfg_wr) cfg_err <= !len_ok;
    end

    AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !len_ok) |=> ($stable(pend_len) && $stable(pend_byp) && cfg_err)); // R8

endmodule

// File: rtl/rs_blk_seq.sv
// Codeword sequencer: counts symbols within a codeword, freezes the length
// and bypass setting on the first symbol, and marks the check-byte phase.
// Assumes: step is high exactly on cycles where one symbol moves forward.
module rs_blk_seq
    import rs_enc_pkg::*;
#(
    parameter int DEF_LEN = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  sym_t pend_len,
    input  logic pend_byp,
    output logic par_phase,
    output logic blk_end,
    output logic eff_byp
);

    sym_t cnt;
    sym_t act_len;
    logic act_byp;
    logic first;
    sym_t eff_len;
    sym_t msg_len;

    assign first     = (cnt == '0);
    assign eff_len   = first ? pend_len : act_len;
    assign eff_byp   = first ? pend_byp : act_byp;
    assign msg_len   = eff_len - sym_t'(NPAR);
    assign par_phase = !eff_byp && (cnt >= msg_len);
    assign blk_end   = !eff_byp && (cnt == (eff_len - sym_t'(1)));

    // Freeze the pending setting when a codeword's first symbol moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len <= sym_t'(DEF_LEN);
            act_byp <= 1'b0;
        end else if (step && first) begin
            act_len <= pend_len;
            act_byp <= pend_byp;
        end
    end

    // Symbol position within the codeword; idle at zero in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (step && !eff_byp)   cnt <= blk_end ? '0 : cnt + sym_t'(1);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (cnt < act_len)); // R2
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> ($stable(act_len) && $stable(act_byp))); // R7

endmodule

// File: rtl/rs_parity_lfsr.sv
// Check-symbol generator: a division LFSR by the generator polynomial,
// one stage per check symbol, unloading the remainder top stage first.
// Assumes: en_msg and en_shift are never high together.
module rs_parity_lfsr
    import rs_enc_pkg::*;
#(
    parameter sym_t POLY_TAPS  = 8'h1D,
    parameter int   FIRST_ROOT = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_msg,
    input  logic en_shift,
    input  logic drain_last,
    input  sym_t din,
    output sym_t par_top
);

    localparam logic [NPAR*SYM_W-1:0] GCOEF = gen_coefs(POLY_TAPS, FIRST_ROOT);

    logic [NPAR*SYM_W-1:0] pr_flat;
    sym_t fb;

    assign par_top = pr_flat[(NPAR-1)*SYM_W +: SYM_W];
    assign fb      = din ^ par_top;

    for (genvar i = 0; i < NPAR; i++) begin : g_stage
        localparam sym_t COEF = GCOEF[i*SYM_W +: SYM_W];
        sym_t prev;
        sym_t term;
        sym_t q;

        if (i == 0) begin : g_head
            assign prev = '0;
        end else begin : g_tail
            assign prev = pr_flat[(i-1)*SYM_W +: SYM_W];
        end

        assign term = gf_mul(COEF, fb, POLY_TAPS);
        assign pr_flat[i*SYM_W +: SYM_W] = q;

        // Fold a message symbol in, or shift the remainder toward the output.
        always_ff @(posedge clk) begin
            if (!rst_n)         q <= '0;
            else if (en_msg)    q <= prev ^ term;
            else if (en_shift)  q <= prev;
        end
    end

    AST_DRAINED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (en_shift && drain_last) |=> (pr_flat == '0)); // R1

endmodule

// File: rtl/rs_out_pipe.sv
// Two-register output pipeline advanced by one shared enable, giving the
// fixed two-cycle latency and holding its contents while stalled.
// Assumes: ce is low only while the output register holds an unread byte.
module rs_out_pipe
    import rs_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic in_v,
    input  sym_t in_d,
    input  logic in_last,
    output logic out_v,
    output sym_t out_d,
    output logic out_last
);

    logic s1_v;
    sym_t s1_d;
    logic s1_last;

    // First register: the symbol chosen this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_d    <= '0;
            s1_last <= 1'b0;
        end else if (ce) begin
            s1_v    <= in_v;
            s1_d    <= in_d;
            s1_last <= in_v && in_last;
        end
    end

    // Second register: the byte offered downstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v    <= 1'b0;
            out_d    <= '0;
            out_last <= 1'b0;
        end else if (ce) begin
            out_v    <= s1_v;
            out_d    <= s1_d;
            out_last <= s1_last;
        end
    end

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v && !ce) |=> (out_v && $stable(out_d) && $stable(out_last))); // R6

endmodule

// File: rtl/rs_encoder.sv
// Top level of the programmable shortened Reed-Solomon encoder. It joins
// the config register, sequencer, check generator and output pipeline, and
// derives the stream handshakes.
// Assumes: downstream holds nothing against in_valid; stalls come via out_ready.
module rs_encoder
    import rs_enc_pkg::*;
#(
    parameter int   MIN_LEN    = 50,
    parameter int   MAX_LEN    = 255,
    parameter int   DEF_LEN    = 255,
    parameter int   FIRST_ROOT = 0,
    parameter sym_t POLY_TAPS  = 8'h1D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [SYM_W-1:0] cfg_len,
    input  logic             cfg_bypass,
    output logic             cfg_err,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SYM_W-1:0] out_data,
    output logic             out_last
);

    sym_t pend_len;
    logic pend_byp;
    logic par_phase;
    logic blk_end;
    logic eff_byp;
    sym_t par_top;
    logic ce;
    logic take;
    logic shift;
    logic step;
    sym_t s1_src;

    // Pipeline moves unless a byte waits at the output unread.
    assign ce       = !out_valid || out_ready;
    assign in_ready = ce && !par_phase;
    assign take     = in_valid && in_ready;
    assign shift    = ce && par_phase;
    assign step     = take || shift;
    assign s1_src   = par_phase ? par_top : in_data;

    rs_cfg_regs #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .DEF_LEN (DEF_LEN)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_len    (cfg_len),
        .cfg_bypass (cfg_bypass),
        .pend_len   (pend_len),
        .pend_byp   (pend_byp),
        .cfg_err    (cfg_err)
    );

    rs_blk_seq #(
        .DEF_LEN (DEF_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .pend_len  (pend_len),
        .pend_byp  (pend_byp),
        .par_phase (par_phase),
        .blk_end   (blk_end),
        .eff_byp   (eff_byp)
    );

    rs_parity_lfsr #(
        .POLY_TAPS  (POLY_TAPS),
        .FIRST_ROOT (FIRST_ROOT)
    ) u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_msg     (take && !eff_byp),
        .en_shift   (shift),
        .drain_last (blk_end),
        .din        (in_data),
        .par_top    (par_top)
    );

    rs_out_pipe u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .in_v     (step),
        .in_d     (s1_src),
        .in_last  (shift && blk_end),
        .out_v    (out_valid),
        .out_d    (out_data),
        .out_last (out_last)
    );

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R3
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R6
    AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n, 1) && $past(take, 2) && $past(ce, 1))
        |-> (out_valid && (out_data == $past(in_data, 2)))); // R5

endmodule

// File: tb/rs_encoder_tb.sv
module rs_encoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_len = 8'd0;
    logic       cfg_bypass = 1'b0;
    logic       cfg_err;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'd0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_last;

    int nchk = 0;
    int nfail = 0;
    int cyc_total = 0;
    int rmode = 0;
    int acc_cyc = 0;
    logic [7:0] pat = 8'd0;
    logic [7:0] cap_d[$];
    logic       cap_l[$];
    logic [7:0] exp_msg[$];

    // rows: codeword length (or byte count in bypass), bypass, seed, ready mode
    localparam int VEC [6][4] = '{
        '{50, 0, 11, 0}, '{255, 0, 22, 1}, '{120, 0, 33, 1},
        '{51, 0, 44, 0}, '{40, 1, 55, 1}, '{66, 0, 77, 1}};

    always #4 clk = ~clk;

    rs_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_len(cfg_len),
        .cfg_bypass(cfg_bypass), .cfg_err(cfg_err), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

    // downstream readiness: 0 always, 1 repeating gaps, 2 held off
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        pat <= pat + 8'd1;
        out_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? !(pat[1] & pat[0]) : 1'b0;
    end

    always @(negedge clk)
        if (rst_n && out_valid && out_ready) begin
            cap_d.push_back(out_data);
            cap_l.push_back(out_last);
        end

    always @(posedge clk)
        if (cyc_total == 150000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_total);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end

    function automatic logic [7:0] mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'd0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(int len, bit byp);
        cfg_wr = 1'b1; cfg_len = 8'(len); cfg_bypass = byp;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(logic [7:0] d);
        in_valid = 1'b1; in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        acc_cyc = cyc_total;
    endtask

    // send one codeword's message (or cnt bytes in bypass); optional mid write
    task automatic run_block(int n, bit byp, int seed, int mid_len, int mid_at);
        int cnt = byp ? n : n - 16;
        int first_acc = 0;
        logic [7:0] b;
        exp_msg.delete();
        for (int i = 0; i < cnt; i++) begin
            if (i == mid_at) begin
                in_valid = 1'b0;
                cfg_write(mid_len, 1'b0);
            end
            b = 8'((seed * 37 + i * 13 + (i >> 3)) & 255);
            exp_msg.push_back(b);
            send(b);
            if (i == 0) first_acc = acc_cyc;
        end
        if (!byp) chk(in_ready == 1'b0, "R4", "in_ready in check phase", in_ready, 0);
        in_valid = 1'b0;
        if (rmode == 0 && mid_at < 0)
            chk(acc_cyc - first_acc == cnt - 1, "R4", "message accept cycles",
                acc_cyc - first_acc, cnt - 1);
    endtask

    task automatic check_block(int n, bit byp, string tag);
        int t = 0;
        int bad = 0;
        int badsyn = 0;
        int lastbad = 0;
        int cnt = byp ? n : n - 16;
        logic [7:0] s;
        logic [7:0] root;
        while (cap_d.size() < n && t < 3000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        chk(cap_d.size() == n, tag, "output byte count", cap_d.size(), n);
        for (int i = 0; i < cnt && i < cap_d.size(); i++)
            if (cap_d[i] != exp_msg[i]) bad++;
        chk(bad == 0, byp ? "R9" : "R1", "message bytes differing", bad, 0);
        if (!byp && cap_d.size() == n) begin
            root = 8'd1;
            for (int r = 0; r < 16; r++) begin
                s = 8'd0;
                for (int i = 0; i < n; i++) s = mul(s, root) ^ cap_d[i];
                if (s != 8'd0) badsyn++;
                root = mul(root, 8'd2);
            end
            chk(badsyn == 0, "R1", "nonzero syndromes", badsyn, 0);
        end
        for (int i = 0; i < cap_l.size(); i++)
            if (cap_l[i] != (!byp && i == n - 1)) lastbad++;
        chk(lastbad == 0, byp ? "R9" : "R3", "misplaced last flags", lastbad, 0);
        cap_d.delete();
        cap_l.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
        chk(cfg_err == 1'b0, "R10", "cfg_err after reset", cfg_err, 0);
        run_block(255, 1'b0, 5, 0, -1);
        check_block(255, 1'b0, "R10");

        for (int v = 0; v < 6; v++) begin
            rmode = VEC[v][3];
            cfg_write(VEC[v][1] != 0 ? 100 : VEC[v][0], VEC[v][1] != 0);
            run_block(VEC[v][0], VEC[v][1] != 0, VEC[v][2], 0, -1);
            check_block(VEC[v][0], VEC[v][1] != 0, "R2");
        end

        // R5: two-cycle latency in bypass with an empty pipeline
        rmode = 0;
        cfg_write(100, 1'b1);
        repeat (2) @(negedge clk);
        send(8'h5A);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R5", "out_valid one cycle after accept", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R5", "out_valid two cycles after accept", out_valid, 1);
        chk(out_data == 8'h5A, "R5", "out_data two cycles after accept", out_data, 8'h5A);
        repeat (3) @(negedge clk);
        cap_d.delete(); cap_l.delete();

        // R6: held-off output keeps its byte and blocks input
        rmode = 2;
        repeat (2) @(negedge clk);
        send(8'hA1);
        send(8'hB2);
        in_valid = 1'b0;
        chk(out_valid && out_data == 8'hA1, "R6", "held output byte", out_data, 8'hA1);
        chk(in_ready == 1'b0, "R6", "in_ready while held", in_ready, 0);
        repeat (3) @(negedge clk);
        chk(out_valid && out_data == 8'hA1, "R6", "byte after 3 held cycles", out_data, 8'hA1);
        rmode = 0;
        repeat (6) @(negedge clk);
        chk(cap_d.size() == 2 && cap_d[0] == 8'hA1 && cap_d[1] == 8'hB2, "R6",
            "bytes released after hold", cap_d.size(), 2);
        cap_d.delete(); cap_l.delete();

        // R8: illegal lengths are ignored and flagged
        cfg_write(80, 1'b0);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R8", "cfg_err after legal write", cfg_err, 0);
        cfg_write(49, 1'b0);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R8", "cfg_err after length 49", cfg_err, 1);
        cfg_write(0, 1'b1);
        run_block(80, 1'b0, 91, 0, -1);
        check_block(80, 1'b0, "R8");
        cfg_write(50, 1'b0);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R8", "cfg_err cleared by legal write", cfg_err, 0);

        // R7: length written mid-codeword waits for the next codeword
        rmode = 1;
        cfg_write(60, 1'b0);
        run_block(60, 1'b0, 13, 50, 10);
        check_block(60, 1'b0, "R7");
        run_block(50, 1'b0, 17, 0, -1);
        check_block(50, 1'b0, "R7");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule